// File: doc/BRIEF.md
# Shadow-Banked Integer Register File

This block is a 32-entry integer register file with 64-bit entries, two combinational read ports and one clocked write port. Eight of its register numbers (8 to 14 and 25) have a second, shadow copy; a single view bit decides whether those numbers reach the normal copy or the shadow copy. Every other register number reaches the same storage in both views, and register 31 is a constant zero.

A trap handler pulses the enter strobe to make the shadow copies visible, and the return-from-exception path pulses the exit strobe to bring back the normal copies. The exit strobe carries the low bit of the saved return address. When that bit is 1, the handler is going back into privileged code and the view does not change. A strobe that asks for the view already in effect is a protocol error and is reported on a one-cycle error output. Switching only moves the view bit; no register contents are copied.

Top module: `shadow_regfile`

## Requirements
- R1: While reset is held and in the first cycle after it, the shadow view is active (`shadowActive`=1), `modeErr` is 0 and every register reads 0.
- R2: Register numbers 8, 9, 10, 11, 12, 13, 14 and 25 are banked. A write to one of them in one view is not visible in the other view, and it is still there when its view returns.
- R3: All other register numbers from 0 to 30 use one storage shared by both views.
- R4: An enter strobe alone, in the normal view, sets `shadowActive` from the next cycle on. It raises no error.
- R5: An exit strobe alone with `exitRetLsb`=0, in the shadow view, clears `shadowActive` from the next cycle on. It raises no error.
- R6: An exit strobe with `exitRetLsb`=1 changes neither the view nor `modeErr`.
- R7: An enter strobe in the shadow view, or an exit strobe with `exitRetLsb`=0 in the normal view, raises `modeErr` for exactly the next cycle and leaves the view unchanged.
- R8: Enter and exit strobes in the same cycle raise `modeErr` for the next cycle and leave the view unchanged.
- R9: A write in the same cycle as a view switch goes to the bank that was visible before the switch.
- R10: Register 31 reads 0 on both ports in both views and ignores writes.
- R11: Both read ports are combinational and independent. A write becomes readable in the cycle after its clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rdAddrA | input | 5 | Read port A register number |
| rdDataA | output | 64 | Read port A data |
| rdAddrB | input | 5 | Read port B register number |
| rdDataB | output | 64 | Read port B data |
| wrEn | input | 1 | Write enable |
| wrAddr | input | 5 | Write register number |
| wrData | input | 64 | Write data |
| enterReq | input | 1 | Request the shadow view |
| exitReq | input | 1 | Request the normal view |
| exitRetLsb | input | 1 | Bit 0 of the return address that comes with exitReq |
| shadowActive | output | 1 | 1 while the shadow view is visible |
| modeErr | output | 1 | One-cycle flag for a redundant or conflicting view request |

## Verification
The properties assume that the strobes, the write enable and all register numbers are known values at every rising edge after reset, and that each strobe acts as a single-cycle request evaluated against the current view. The bench changes its inputs only on falling edges and draws every value from defined constants or `$urandom`, so no unknown value reaches an edge. The random phase issues strobes that are sometimes redundant, sometimes simultaneous and sometimes paired with writes to banked numbers, so both the error paths and the switch-cycle write path are exercised under those assumptions.

// File: rtl/srf_pkg.sv
package srf_pkg;
  // Register numbers that own a shadow copy: 8..14 and 25
  localparam logic [31:0] BANKED_MASK = 32'h0200_7F00;

  typedef struct packed {
    logic shadowSel;  // current view steering for banked entries
    logic wrEn;       // write qualified (never targets the zero register)
  } ctrl_strobe_t;
endpackage

// File: rtl/srf_mode_ctrl.sv
module srf_mode_ctrl
  import srf_pkg::*;
#(
  parameter int NUM_REGS = 32,
  localparam int ADDR_W = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enterReq,
  input  logic              exitReq,
  input  logic              exitRetLsb,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  output ctrl_strobe_t      strobe,
  output logic              modeErr
);
  localparam logic [ADDR_W-1:0] ZERO_REG = ADDR_W'(NUM_REGS - 1);

  logic shadowSel, nextSel, errNext;

  always_comb begin
    nextSel = shadowSel;
    errNext = 1'b0;
    if (enterReq && exitReq) begin
      errNext = 1'b1;
    end else if (enterReq) begin
      if (shadowSel) errNext = 1'b1;
      else           nextSel = 1'b1;
    end else if (exitReq && !exitRetLsb) begin
      if (!shadowSel) errNext = 1'b1;
      else            nextSel = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowSel <= 1'b1;
      modeErr   <= 1'b0;
    end else begin
      shadowSel <= nextSel;
      modeErr   <= errNext;
    end
  end

  assign strobe.shadowSel = shadowSel;
  assign strobe.wrEn      = wrEn && (wrAddr != ZERO_REG);

  AST_ENTER_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (enterReq && !exitReq && !shadowSel) |=> (shadowSel && !modeErr)); // R4
  AST_EXIT_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (exitReq && !enterReq && !exitRetLsb && shadowSel) |=> (!shadowSel && !modeErr)); // R5
  AST_LSB_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (exitReq && !enterReq && exitRetLsb) |=> ($stable(shadowSel) && !modeErr)); // R6
  AST_REDUNDANT_ERR: assert property (@(posedge clk) disable iff (!rstN)
    ((enterReq && !exitReq && shadowSel) || (exitReq && !enterReq && !exitRetLsb && !shadowSel))
      |=> (modeErr && $stable(shadowSel))); // R7
  AST_BOTH_ERR: assert property (@(posedge clk) disable iff (!rstN)
    (enterReq && exitReq) |=> (modeErr && $stable(shadowSel))); // R8
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!enterReq && !exitReq) |=> ($stable(shadowSel) && !modeErr)); // R7
endmodule

// File: rtl/srf_storage.sv
module srf_storage
  import srf_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 64,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobe_t      strobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddrA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [ADDR_W-1:0] rdAddrB,
  output logic [DATA_W-1:0] rdDataB
);
  localparam int LAST_REG = NUM_REGS - 1;
  localparam logic [ADDR_W-1:0] ZERO_REG = ADDR_W'(LAST_REG);

  logic [DATA_W-1:0] normArr [NUM_REGS];
  logic [DATA_W-1:0] shadArr [NUM_REGS];

  for (genvar r = 0; r < LAST_REG; r++) begin : gEntry
    logic [DATA_W-1:0] normQ;
    logic hit;
    assign hit = strobe.wrEn && (wrAddr == ADDR_W'(r));

    if (BANKED_MASK[r]) begin : gBanked
      logic [DATA_W-1:0] shadQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          normQ <= '0;
          shadQ <= '0;
        end else if (hit) begin
          if (strobe.shadowSel) shadQ <= wrData;
          else                  normQ <= wrData;
        end
      end
      assign shadArr[r] = shadQ;
    end else begin : gShared
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)    normQ <= '0;
        else if (hit) normQ <= wrData;
      end
      assign shadArr[r] = '0;
    end
    assign normArr[r] = normQ;
  end

  assign normArr[LAST_REG] = '0;
  assign shadArr[LAST_REG] = '0;

  function automatic logic [DATA_W-1:0] pick(input logic [ADDR_W-1:0] a, input logic sel);
    return (sel && BANKED_MASK[a]) ? shadArr[a] : normArr[a];
  endfunction

  assign rdDataA = pick(rdAddrA, strobe.shadowSel);
  assign rdDataB = pick(rdAddrB, strobe.shadowSel);

  AST_ZERO_READ_A: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddrA == ZERO_REG) |-> (rdDataA == '0)); // R10
  AST_ZERO_READ_B: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddrB == ZERO_REG) |-> (rdDataB == '0)); // R10
  AST_NO_ZERO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn |-> (wrAddr != ZERO_REG)); // R10
  AST_SHARED_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && !BANKED_MASK[wrAddr]) |=> (normArr[$past(wrAddr)] == $past(wrData))); // R3
endmodule

// File: rtl/shadow_regfile.sv
module shadow_regfile
  import srf_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 64,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] rdAddrA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [ADDR_W-1:0] rdAddrB,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              enterReq,
  input  logic              exitReq,
  input  logic              exitRetLsb,
  output logic              shadowActive,
  output logic              modeErr
);
  ctrl_strobe_t strobe;

  srf_mode_ctrl #(.NUM_REGS(NUM_REGS)) uCtrl (
    .clk(clk), .rstN(rstN), .enterReq(enterReq), .exitReq(exitReq),
    .exitRetLsb(exitRetLsb), .wrEn(wrEn), .wrAddr(wrAddr),
    .strobe(strobe), .modeErr(modeErr)
  );

  srf_storage #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) uStore (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddrA(rdAddrA), .rdDataA(rdDataA), .rdAddrB(rdAddrB), .rdDataB(rdDataB)
  );

  assign shadowActive = strobe.shadowSel;
endmodule

// File: tb/sim_shadow_regfile.sv
module sim_shadow_regfile;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  rdAddrA = '0, rdAddrB = '0, wrAddr = '0;
  logic [63:0] rdDataA, rdDataB, wrData = '0;
  logic        wrEn = 1'b0, enterReq = 1'b0, exitReq = 1'b0, exitRetLsb = 1'b0;
  logic        shadowActive, modeErr;

  int checks = 0;
  int errors = 0;
  string curReq = "R1";

  // Behavioural reference state
  logic [63:0] mNorm [32];
  logic [63:0] mShad [32];
  logic        mView;
  logic        mErr;

  always #2 clk = ~clk;

  shadow_regfile u0 (
    .clk(clk), .rstN(rstN), .rdAddrA(rdAddrA), .rdDataA(rdDataA),
    .rdAddrB(rdAddrB), .rdDataB(rdDataB), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .enterReq(enterReq), .exitReq(exitReq),
    .exitRetLsb(exitRetLsb), .shadowActive(shadowActive), .modeErr(modeErr)
  );

  function automatic bit isBanked(input int n);
    return (n >= 8 && n <= 14) || n == 25;
  endfunction

  function automatic logic [63:0] mRead(input int n);
    if (n == 31) return '0;
    if (mView && isBanked(n)) return mShad[n];
    return mNorm[n];
  endfunction

  task automatic modelReset();
    for (int i = 0; i < 32; i++) begin
      mNorm[i] = '0;
      mShad[i] = '0;
    end
    mView = 1'b1;
    mErr  = 1'b0;
  endtask

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", curReq, what, act, exp);
    end
  endtask

  task automatic compareAll();
    chk("rdDataA", rdDataA, mRead(int'(rdAddrA)));
    chk("rdDataB", rdDataB, mRead(int'(rdAddrB)));
    chk("shadowActive", 64'(shadowActive), 64'(mView));
    chk("modeErr", 64'(modeErr), 64'(mErr));
  endtask

  // Called at a falling edge with inputs already set: compare, then advance one cycle.
  task automatic step();
    #1;
    compareAll();
    @(posedge clk);
    if (!rstN) begin
      modelReset();
    end else begin
      if (wrEn && wrAddr != 5'd31) begin
        if (mView && isBanked(int'(wrAddr))) mShad[wrAddr] = wrData;
        else                                 mNorm[wrAddr] = wrData;
      end
      mErr = 1'b0;
      if (enterReq && exitReq) mErr = 1'b1;
      else if (enterReq) begin
        if (mView) mErr = 1'b1; else mView = 1'b1;
      end else if (exitReq && !exitRetLsb) begin
        if (!mView) mErr = 1'b1; else mView = 1'b0;
      end
    end
    @(negedge clk);
  endtask

  task automatic idle();
    wrEn = 0; enterReq = 0; exitReq = 0; exitRetLsb = 0;
  endtask

  task automatic wr(input int n, input logic [63:0] d);
    idle(); wrEn = 1; wrAddr = 5'(n); wrData = d; step(); wrEn = 0;
  endtask

  task automatic rd(input int a, input int b);
    idle(); rdAddrA = 5'(a); rdAddrB = 5'(b); step();
  endtask

  task automatic strobe(input bit en, input bit ex, input bit lsb);
    idle(); enterReq = en; exitReq = ex; exitRetLsb = lsb; step(); idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int bankedList[8] = '{8, 9, 10, 11, 12, 13, 14, 25};
    modelReset();
    @(posedge clk);
    @(negedge clk);
    // R1: reset state
    curReq = "R1";
    for (int i = 0; i < 32; i += 2) rd(i, i + 1);
    rstN = 1'b1;
    rd(8, 25);

    // R2: banked entries differ per view
    curReq = "R2";
    foreach (bankedList[k]) wr(bankedList[k], 64'hA5A5_0000_0000_0000 + 64'(k));
    foreach (bankedList[k]) rd(bankedList[k], bankedList[(k + 1) % 8]);
    strobe(0, 1, 0);
    foreach (bankedList[k]) rd(bankedList[k], bankedList[k]);
    foreach (bankedList[k]) wr(bankedList[k], 64'h5A5A_1111_0000_0000 + 64'(k));
    strobe(1, 0, 0);
    foreach (bankedList[k]) rd(bankedList[k], 15);

    // R3: shared entries
    curReq = "R3";
    wr(3, 64'h0123_4567_89AB_CDEF); wr(15, 64'hFEED); wr(24, 64'hBEEF); wr(30, 64'h7);
    rd(3, 15);
    strobe(0, 1, 0);
    rd(24, 30);
    wr(7, 64'hCAFE);
    strobe(1, 0, 0);
    rd(7, 3);

    // R4 and R5: clean switches
    curReq = "R5"; strobe(0, 1, 0); rd(9, 9);
    curReq = "R4"; strobe(1, 0, 0); rd(9, 9);

    // R6: exit with lsb set keeps the view
    curReq = "R6"; strobe(0, 1, 1); rd(10, 10);

    // R7: redundant requests
    curReq = "R7"; strobe(1, 0, 0); rd(11, 0);
    strobe(0, 1, 0); strobe(0, 1, 0); rd(11, 0);
    strobe(0, 1, 1); rd(11, 0);

    // R8: both strobes together, in each view
    curReq = "R8"; strobe(1, 1, 0); rd(12, 0);
    strobe(1, 0, 0); strobe(1, 1, 1); rd(12, 0);

    // R9: write during the switch cycle goes to the old bank
    curReq = "R9";
    idle(); wrEn = 1; wrAddr = 5'd13; wrData = 64'h5151; exitReq = 1; step(); idle();
    rd(13, 13);
    idle(); wrEn = 1; wrAddr = 5'd25; wrData = 64'h7272; enterReq = 1; step(); idle();
    rd(25, 13);
    strobe(0, 1, 0); rd(25, 13);

    // R10: zero register
    curReq = "R10";
    wr(31, 64'hFFFF_FFFF_FFFF_FFFF); rd(31, 31);
    strobe(1, 0, 0); wr(31, 64'h1); rd(31, 31);

    // R11: same-cycle read returns old value, next cycle the new one
    curReq = "R11";
    idle(); wrEn = 1; wrAddr = 5'd20; wrData = 64'h2020; rdAddrA = 5'd20; rdAddrB = 5'd14;
    step(); idle(); rd(20, 14);

    // Random mixed traffic
    curReq = "R2";
    for (int c = 0; c < 3000; c++) begin
      idle();
      rdAddrA = 5'($urandom); rdAddrB = 5'($urandom);
      wrEn = ($urandom % 2) == 0;
      wrAddr = ($urandom % 2) ? 5'(bankedList[$urandom % 8]) : 5'($urandom);
      wrData = {$urandom, $urandom};
      enterReq = ($urandom % 6) == 0;
      exitReq = ($urandom % 6) == 0;
      exitRetLsb = ($urandom % 3) == 0;
      step();
    end
    idle();
    rd(0, 31);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule